// File: doc/BRIEF.md
# Six-Mode Logical Arithmetic Shifter

This block moves the bits of one data word left or right by a variable distance and puts the result in an output register. A 3-bit operation code picks one of six modes: two logical shifts that fill with zero, two arithmetic shifts that fill with an edge bit of the input, and two rotates. The word width is a parameter and defaults to 8 bits. The amount input is wide enough to carry every value from 0 through WIDTH, and larger values that fit in it are also accepted.

The shift network is combinational. It is built once as a left-going logarithmic barrel. Right-going modes reverse the bit order on the way in and on the way out. The result reaches the output register on a clock edge where the enable input is high. A synchronous reset clears the register.

Top module: `shift_unit`

## Requirements
- R1: Operation code 000 shifts the word left and fills the freed low bits with 0; input 10010101 moved by 2 gives 01010100.
- R2: Operation code 001 shifts the word right and fills the freed high bits with 0; input 10010101 moved by 3 gives 00010010.
- R3: Operation code 010 shifts the word left and fills the freed low bits with copies of the input's bit 0; input 10010101 moved by 3 gives 10101111.
- R4: Operation code 011 shifts the word right and fills the freed high bits with copies of the input's top bit; input 10010101 moved by 2 gives 11100101.
- R5: Operation code 100 rotates left and 101 rotates right, with the distance taken modulo WIDTH; on 8 bits, 10010101 rotated left by 3 and rotated right by 5 both give 10101100.
- R6: An amount of 0 returns the input word unchanged for every operation code.
- R7: Operation codes 110 and 111 return the input word unchanged whatever the amount.
- R8: For codes 000 to 011, an amount of WIDTH or more gives a word made only of the fill bit for that code.
- R9: The output register takes the new result only on a clock edge with en high, and otherwise keeps its value.
- R10: With rst high at a clock edge, the output becomes all zeros on that edge. This takes priority over en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Load enable for the output register |
| op | input | 3 | Operation code |
| amt | input | $clog2(WIDTH+1) | Shift or rotate distance |
| din | input | WIDTH | Data word to shift |
| q | output | WIDTH | Registered result |

## Verification
The bench sweeps every 8-bit input against every amount the port can carry, from 0 through 15, under all eight operation codes. This covers the amounts at and past WIDTH, where a shifter that saturated at the wrong point, or wrapped its shift distance the way a rotate does, would leave data bits in what should be a pure fill word. It also catches a rotate that failed to reduce amounts above 7 and so dropped or cleared bits. The arithmetic modes use input words with different edge bits, which exposes a design that filled from the wrong end or filled with zeros. Separate steps change the inputs while en is low and assert reset together with en, which exposes a register that loads without its enable or lets a load win over reset.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [2:0] {
    OP_LSHL  = 3'd0,
    OP_LSHR  = 3'd1,
    OP_ASHL  = 3'd2,
    OP_ASHR  = 3'd3,
    OP_ROTL  = 3'd4,
    OP_ROTR  = 3'd5,
    OP_PASSA = 3'd6,
    OP_PASSB = 3'd7
  } shf_op_e;

  typedef struct packed {
    logic right;   // operate on a reversed word
    logic rotate;  // wrap bits instead of filling
    logic fill;    // fill bit value for shifts
    logic sat;     // amount reaches or passes the width
    logic bypass;  // return the input unchanged
  } shf_ctl_t;

endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH + 1),
  localparam int STG   = $clog2(WIDTH)
) (
  input  logic [2:0]       op,
  input  logic [AMT_W-1:0] amt,
  input  logic             lsb,
  input  logic             msb,
  output shf_ctl_t         ctl,
  output logic [STG-1:0]   ramt
);

  shf_op_e opc;
  assign opc = shf_op_e'(op);

  always_comb begin
    ctl        = '0;
    ctl.sat    = (amt >= AMT_W'(WIDTH));
    unique case (opc)
      OP_LSHL: ctl.fill = 1'b0;
      OP_LSHR: begin ctl.right = 1'b1; ctl.fill = 1'b0; end
      OP_ASHL: ctl.fill = lsb;
      OP_ASHR: begin ctl.right = 1'b1; ctl.fill = msb; end
      OP_ROTL: begin ctl.rotate = 1'b1; ctl.sat = 1'b0; end
      OP_ROTR: begin ctl.rotate = 1'b1; ctl.right = 1'b1; ctl.sat = 1'b0; end
      default: begin ctl.bypass = 1'b1; ctl.sat = 1'b0; end
    endcase
  end

  // rotates wrap the distance; shifts past the width are handled by sat
  assign ramt = ctl.rotate ? STG'(amt % AMT_W'(WIDTH)) : STG'(amt);

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int STG = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  shf_ctl_t         ctl,
  input  logic [STG-1:0]   ramt,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] res;
  logic [WIDTH-1:0] stage [STG+1];

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      src[i] = ctl.right ? din[WIDTH-1-i] : din[i];
  end

  assign stage[0] = src;

  generate
    for (genvar k = 0; k < STG; k++) begin : g_stage
      localparam int SH = 1 << k;
      logic [WIDTH-1:0] moved;
      assign moved = ctl.rotate
                   ? {stage[k][WIDTH-1-SH:0], stage[k][WIDTH-1:WIDTH-SH]}
                   : {stage[k][WIDTH-1-SH:0], {SH{ctl.fill}}};
      assign stage[k+1] = ramt[k] ? moved : stage[k];
    end
  endgenerate

  assign res = ctl.sat ? {WIDTH{ctl.fill}} : stage[STG];

  always_comb begin
    for (int i = 0; i < WIDTH; i++)
      dout[i] = ctl.right ? res[WIDTH-1-i] : res[i];
  end

endmodule

// File: rtl/shf_outreg.sv
module shf_outreg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shifter_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH + 1),
  localparam int STG   = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [2:0]       op,
  input  logic [AMT_W-1:0] amt,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);

  shf_ctl_t         ctl;
  logic [STG-1:0]   ramt;
  logic [WIDTH-1:0] shifted;
  logic [WIDTH-1:0] nxt;

  shf_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .op(op), .amt(amt), .lsb(din[0]), .msb(din[WIDTH-1]),
    .ctl(ctl), .ramt(ramt)
  );

  shf_barrel #(.WIDTH(WIDTH)) u_barrel (
    .din(din), .ctl(ctl), .ramt(ramt), .dout(shifted)
  );

  assign nxt = ctl.bypass ? din : shifted;

  shf_outreg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst(rst), .en(en), .d(nxt), .q(q)
  );

endmodule

// File: rtl/shift_unit_chk.sv
module shift_unit_chk #(
  parameter int WIDTH = 8,
  localparam int AMT_W = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [2:0]       op,
  input logic [AMT_W-1:0] amt,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q
);

  logic rst_seen = 1'b0;
  always @(posedge clk) rst_seen <= rst;

  always @(negedge clk) begin
    if (rst_seen === 1'b1)
      p_reset_zero_r10: assert (q == '0);
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q));

  p_zero_amt_r6: assert property (@(posedge clk) disable iff (rst)
    (en && amt == '0) |=> q == $past(din));

  p_pass_r7: assert property (@(posedge clk) disable iff (rst)
    (en && op[2:1] == 2'b11) |=> q == $past(din));

  p_lshl_sat_r8: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd0 && amt >= AMT_W'(WIDTH)) |=> q == '0);

  p_ashr_sat_r4: assert property (@(posedge clk) disable iff (rst)
    (en && op == 3'd3 && amt >= AMT_W'(WIDTH)) |=> q == {WIDTH{$past(din[WIDTH-1])}});

  p_rot_count_r5: assert property (@(posedge clk) disable iff (rst)
    (en && op[2:1] == 2'b10) |=> $countones(q) == $countones($past(din)));

endmodule

bind shift_unit shift_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .en(en), .op(op), .amt(amt), .din(din), .q(q)
);

// File: tb/shift_unit_bench.sv
module shift_unit_bench;

  localparam int W      = 8;
  localparam int AW     = $clog2(W + 1);
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en  = 1'b0;
  logic [2:0]    op  = '0;
  logic [AW-1:0] amt = '0;
  logic [W-1:0]  din = '0;
  logic [W-1:0]  q;

  int total = 0;
  int bad   = 0;

  always #(PERIOD/2) clk = ~clk;

  shift_unit #(.WIDTH(W)) u_shift_unit (
    .clk(clk), .rst(rst), .en(en), .op(op), .amt(amt), .din(din), .q(q)
  );

  function automatic logic [W-1:0] model(input logic [2:0] o, input int a,
                                         input logic [W-1:0] d);
    logic [W-1:0] r;
    logic f;
    int rr;
    f  = (o == 3'd2) ? d[0] : (o == 3'd3) ? d[W-1] : 1'b0;
    rr = a % W;
    for (int i = 0; i < W; i++) begin
      case (o)
        3'd0, 3'd2: r[i] = (a < W && i - a >= 0) ? d[i-a] : f;
        3'd1, 3'd3: r[i] = (a < W && i + a < W) ? d[i+a] : f;
        3'd4:       r[i] = d[(i - rr + W) % W];
        3'd5:       r[i] = d[(i + rr) % W];
        default:    r[i] = d[i];
      endcase
    end
    return r;
  endfunction

  function automatic string tag(input logic [2:0] o, input int a);
    if (o[2:1] == 2'b11) return "R7";
    if (a == 0)          return "R6";
    if (o[2] == 1'b0 && a >= W) return "R8";
    case (o)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    total++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s: q=%b expected=%b (op=%0d amt=%0d din=%b)",
               req, q, exp, op, amt, din);
    end
  endtask

  task automatic apply(input logic [2:0] o, input int a, input logic [W-1:0] d);
    op  = o;
    amt = AW'(a);
    din = d;
    en  = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    din = 8'hA5;
    en  = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R10", '0);
    rst = 1'b0;

    // worked examples on 10010101
    apply(3'd0, 2, 8'b10010101); check("R1", 8'b01010100);
    apply(3'd1, 3, 8'b10010101); check("R2", 8'b00010010);
    apply(3'd2, 3, 8'b10010101); check("R3", 8'b10101111);
    apply(3'd3, 2, 8'b10010101); check("R4", 8'b11100101);
    apply(3'd4, 3, 8'b10010101); check("R5", 8'b10101100);
    apply(3'd5, 5, 8'b10010101); check("R5", 8'b10101100);

    // exhaustive sweep: every op, amount value and input word
    for (int o = 0; o < 8; o++)
      for (int a = 0; a < (1 << AW); a++)
        for (int d = 0; d < (1 << W); d++) begin
          apply(3'(o), a, W'(d));
          check(tag(3'(o), a), model(3'(o), a, W'(d)));
        end

    // R9: inputs change with en low, the register keeps its value
    apply(3'd4, 1, 8'h81);
    check("R9", 8'h03);
    en = 1'b0; op = 3'd0; amt = AW'(4); din = 8'hFF;
    @(negedge clk);
    check("R9", 8'h03);
    op = 3'd6; din = 8'h5A;
    @(negedge clk);
    check("R9", 8'h03);

    // R10: reset wins over enable
    en = 1'b1; rst = 1'b1; op = 3'd6; din = 8'h77;
    @(negedge clk);
    check("R10", '0);
    rst = 1'b0;
    @(negedge clk);
    check("R7", 8'h77);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule